// File: doc/BRIEF.md
# Masked-Address Single-Channel DMA Engine

This block copies data from one memory-mapped region to another over a simple request/grant memory port. Work is split into hops. A hop reads one, two or four words from the source into a small internal buffer, then writes them out to the destination in the same order. After every beat, each side's address advances by its own signed 8-bit byte increment. A per-side bit mask holds chosen address bits at the value they had in the start address. This gives circular windows or fixed addresses without extra logic in the requesting software.

Hops can run back to back until the hop count runs out (free-running). In request-driven mode, each rising edge on any selected hardware request line releases exactly one hop. A lock option keeps the bus request asserted from the read burst into the write burst. Without lock, the request drops for one idle cycle between the two bursts. The live source and destination addresses are visible at all times. A completion flag and a maskable interrupt mark the end of a run. A continue option resumes from the current addresses instead of reloading the start addresses.

Top module: `mdma_channel`

## Requirements
- R1: After reset, `m_req`, `busy`, `done` and `irq` are 0, and `cur_src` and `cur_dst` are 0.
- R2: A hop issues N read beats and then N write beats. Write beat k carries the data returned by read beat k. N comes from `cfg_burst`: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R3: After each granted read (write) beat, the source (destination) address becomes the old address plus the sign-extended 8-bit byte increment, on all unmasked bits.
- R4: When `cfg_*_mask` bit k is 1, address bit k+4 keeps the value it has in the start address. Mask bit 23 governs address bit 27. Address bits 3..0 and 31..28 are never masked.
- R5: In request-driven mode (`cfg_free_run`=0), each 0-to-1 transition of the OR of (`dreq` AND `cfg_req_sel`) releases exactly one hop. Activity on unselected lines starts nothing.
- R6: In free-running mode (`cfg_free_run`=1), hops follow one another without any request until `cfg_hops` hops are done.
- R7: With `cfg_lock`=1, the cycle after the last read grant of a hop is the first write beat. With `cfg_lock`=0, `m_req` is 0 for exactly that one cycle.
- R8: `start` (accepted only while not busy) clears `done`. After the last hop, `done` becomes 1 and `busy` becomes 0. A start with `cfg_hops`=0 sets `done` at once and makes no bus access. `irq` equals `done` AND `cfg_irq_en`. A `done_clr` pulse clears `done`.
- R9: A start with `cfg_cont`=1 keeps `cur_src` and `cur_dst` as they are. A start with `cfg_cont`=0 loads them from the start addresses.
- R10: `m_we` is 1 only on write beats, and `m_size` always carries `cfg_size`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_start | input | AW | Source start address |
| cfg_dst_start | input | AW | Destination start address |
| cfg_src_inc | input | IW | Signed source byte increment |
| cfg_dst_inc | input | IW | Signed destination byte increment |
| cfg_src_mask | input | MW | Source frozen-bit mask (bit k holds address bit k+4) |
| cfg_dst_mask | input | MW | Destination frozen-bit mask |
| cfg_hops | input | CW | Number of hops in a run |
| cfg_burst | input | 2 | Beats per hop selector |
| cfg_size | input | 2 | Word size code passed to the bus |
| cfg_req_sel | input | NREQ | Request lines allowed to trigger hops |
| cfg_free_run | input | 1 | 1: hops run without requests |
| cfg_cont | input | 1 | 1: start keeps current addresses |
| cfg_lock | input | 1 | 1: hold request across the hop |
| cfg_irq_en | input | 1 | Interrupt enable |
| start | input | 1 | Start pulse |
| done_clr | input | 1 | Completion flag clear pulse |
| dreq | input | NREQ | Hardware request lines |
| m_req | output | 1 | Bus request |
| m_gnt | input | 1 | Bus grant; a beat completes when request and grant are both 1 |
| m_we | output | 1 | 1 for a write beat |
| m_addr | output | AW | Beat address |
| m_size | output | 2 | Word size code |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data, valid in the granted cycle |
| cur_src | output | AW | Live source address |
| cur_dst | output | AW | Live destination address |
| busy | output | 1 | Run in progress |
| done | output | 1 | Completion flag |
| irq | output | 1 | Interrupt |

## Verification
The bench uses the default parameters: 32-bit addresses and data, an 8-bit increment, a 24-bit mask starting at address bit 4, 16-bit hop counter and 13 request lines. At these widths a source address that counts across bit 27 while mask bit 23 is set can be reached. So can a negative increment that wraps a destination inside a fixed 16-byte window, and a request line outside the selected set. Grant stalls from a pseudo-random source hit beats that wait several cycles. A continued run after such a run checks that resumed addresses follow on with no gap.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  localparam int unsigned MAX_BEATS = 4;
  localparam int unsigned BEAT_W    = $clog2(MAX_BEATS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_GAP,
    ST_WR,
    ST_HOPEND
  } hop_state_t;

  // beats per hop from the burst selector
  function automatic logic [BEAT_W:0] beats_of(input logic [1:0] bsel);
    case (bsel)
      2'd0:    beats_of = (BEAT_W+1)'(1);
      2'd1:    beats_of = (BEAT_W+1)'(2);
      default: beats_of = (BEAT_W+1)'(4);
    endcase
  endfunction
endpackage

// File: rtl/mdma_addr_unit.sv
module mdma_addr_unit #(
  parameter int unsigned AW = 32,
  parameter int unsigned IW = 8,
  parameter int unsigned MW = 24,
  parameter int unsigned ML = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic [AW-1:0] start_addr,
  input  logic [IW-1:0] inc,
  input  logic [MW-1:0] mask,
  output logic [AW-1:0] cur
);
  localparam int unsigned MH = ML + MW - 1;

  function automatic logic [AW-1:0] widen_mask(input logic [MW-1:0] m);
    logic [AW-1:0] w;
    w = '0;
    w[MH:ML] = m;
    return w;
  endfunction

  function automatic logic [AW-1:0] sext_inc(input logic [IW-1:0] i);
    return {{(AW-IW){i[IW-1]}}, i};
  endfunction

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] now,
                                              input logic [AW-1:0] base,
                                              input logic [IW-1:0] i,
                                              input logic [MW-1:0] m);
    logic [AW-1:0] frz;
    logic [AW-1:0] sum;
    frz = widen_mask(m);
    sum = now + sext_inc(i);
    return (sum & ~frz) | (base & frz);
  endfunction

  logic [AW-1:0] inc_ext;
  logic [AW-1:0] frozen_bits;
  assign inc_ext     = sext_inc(inc);
  assign frozen_bits = widen_mask(mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cur <= '0;
    else if (load)    cur <= start_addr;
    else if (advance) cur <= step_addr(cur, start_addr, inc, mask);
  end

  // frozen bits equal the start address after every step
  p_mask_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load |=> ((cur ^ start_addr) & frozen_bits) == '0);

  // with nothing frozen the step is a plain signed add
  p_step_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !load && mask == '0 |=> cur == $past(cur) + $past(inc_ext));
endmodule

// File: rtl/mdma_trig.sv
module mdma_trig #(
  parameter int unsigned NREQ = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] dreq,
  input  logic [NREQ-1:0] sel,
  input  logic            take,
  output logic            pend
);
  logic trig, trig_q, rise;
  assign trig = |(dreq & sel);
  assign rise = trig & ~trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      trig_q <= trig;
      if (rise)      pend <= 1'b1;
      else if (take) pend <= 1'b0;
    end
  end

  // a pending hop only appears after a selected rising edge
  p_pend_from_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(rise));
endmodule

// File: rtl/mdma_hop_buf.sv
module mdma_hop_buf #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DW-1:0]            wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] slot [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slot[wr_idx] <= wr_data;
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
  import mdma_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done_clr,
  input  logic [CW-1:0]     cfg_hops,
  input  logic [1:0]        cfg_burst,
  input  logic              cfg_free_run,
  input  logic              cfg_lock,
  input  logic              cfg_cont,
  input  logic              pend,
  input  logic              m_gnt,
  output logic              m_req,
  output logic              m_we,
  output logic              src_adv,
  output logic              dst_adv,
  output logic [BEAT_W-1:0] beat,
  output logic              load_addr,
  output logic              take,
  output logic              busy,
  output logic              done
);
  hop_state_t        state;
  logic [CW-1:0]     hops_left;
  logic              run;
  logic [BEAT_W:0]   nbeats;
  logic              last_beat, go, accept, hop_end, last_hop;

  assign nbeats    = beats_of(cfg_burst);
  assign last_beat = ({1'b0, beat} == nbeats - (BEAT_W+1)'(1));
  assign accept    = start && !run;
  assign load_addr = accept && !cfg_cont;
  assign go        = run && (cfg_free_run || pend) && (hops_left != '0);
  assign take      = (state == ST_IDLE) && go && !cfg_free_run;
  assign m_req     = (state == ST_RD) || (state == ST_WR);
  assign m_we      = (state == ST_WR);
  assign src_adv   = (state == ST_RD) && m_gnt;
  assign dst_adv   = (state == ST_WR) && m_gnt;
  assign hop_end   = (state == ST_HOPEND);
  assign last_hop  = hop_end && (hops_left == CW'(1));
  assign busy      = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat      <= '0;
      hops_left <= '0;
      run       <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (accept) begin
        run       <= (cfg_hops != '0);
        hops_left <= cfg_hops;
        done      <= (cfg_hops == '0);
      end else if (last_hop) begin
        run  <= 1'b0;
        done <= 1'b1;
      end else if (done_clr) begin
        done <= 1'b0;
      end

      case (state)
        ST_IDLE: if (go) begin
          state <= ST_RD;
          beat  <= '0;
        end
        ST_RD: if (m_gnt) begin
          if (last_beat) begin
            beat  <= '0;
            state <= cfg_lock ? ST_WR : ST_GAP;
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        ST_GAP: state <= ST_WR;
        ST_WR: if (m_gnt) begin
          if (last_beat) begin
            beat  <= '0;
            state <= ST_HOPEND;
          end else begin
            beat <= beat + BEAT_W'(1);
          end
        end
        ST_HOPEND: begin
          hops_left <= hops_left - CW'(1);
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_lock_bridge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD) && m_gnt && last_beat && cfg_lock |=> m_req && m_we);

  p_unlock_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD) && m_gnt && last_beat && !cfg_lock |=> !m_req);

  p_beat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> ({1'b0, beat} < nbeats));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_hop |=> done && !busy);
endmodule

// File: rtl/mdma_channel.sv
module mdma_channel
  import mdma_pkg::*;
#(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned IW   = 8,
  parameter int unsigned MW   = 24,
  parameter int unsigned ML   = 4,
  parameter int unsigned CW   = 16,
  parameter int unsigned NREQ = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cfg_src_start,
  input  logic [AW-1:0]   cfg_dst_start,
  input  logic [IW-1:0]   cfg_src_inc,
  input  logic [IW-1:0]   cfg_dst_inc,
  input  logic [MW-1:0]   cfg_src_mask,
  input  logic [MW-1:0]   cfg_dst_mask,
  input  logic [CW-1:0]   cfg_hops,
  input  logic [1:0]      cfg_burst,
  input  logic [1:0]      cfg_size,
  input  logic [NREQ-1:0] cfg_req_sel,
  input  logic            cfg_free_run,
  input  logic            cfg_cont,
  input  logic            cfg_lock,
  input  logic            cfg_irq_en,
  input  logic            start,
  input  logic            done_clr,
  input  logic [NREQ-1:0] dreq,
  output logic            m_req,
  input  logic            m_gnt,
  output logic            m_we,
  output logic [AW-1:0]   m_addr,
  output logic [1:0]      m_size,
  output logic [DW-1:0]   m_wdata,
  input  logic [DW-1:0]   m_rdata,
  output logic [AW-1:0]   cur_src,
  output logic [AW-1:0]   cur_dst,
  output logic            busy,
  output logic            done,
  output logic            irq
);
  logic              src_adv, dst_adv, load_addr, take, pend;
  logic [BEAT_W-1:0] beat;

  mdma_trig #(.NREQ(NREQ)) u_trig (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .sel(cfg_req_sel),
    .take(take), .pend(pend)
  );

  mdma_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .done_clr(done_clr),
    .cfg_hops(cfg_hops), .cfg_burst(cfg_burst), .cfg_free_run(cfg_free_run),
    .cfg_lock(cfg_lock), .cfg_cont(cfg_cont), .pend(pend), .m_gnt(m_gnt),
    .m_req(m_req), .m_we(m_we), .src_adv(src_adv), .dst_adv(dst_adv),
    .beat(beat), .load_addr(load_addr), .take(take), .busy(busy), .done(done)
  );

  mdma_addr_unit #(.AW(AW), .IW(IW), .MW(MW), .ML(ML)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load_addr), .advance(src_adv),
    .start_addr(cfg_src_start), .inc(cfg_src_inc), .mask(cfg_src_mask),
    .cur(cur_src)
  );

  mdma_addr_unit #(.AW(AW), .IW(IW), .MW(MW), .ML(ML)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load_addr), .advance(dst_adv),
    .start_addr(cfg_dst_start), .inc(cfg_dst_inc), .mask(cfg_dst_mask),
    .cur(cur_dst)
  );

  mdma_hop_buf #(.DW(DW), .DEPTH(MAX_BEATS)) u_buf (
    .clk(clk), .wr_en(src_adv), .wr_idx(beat), .wr_data(m_rdata),
    .rd_idx(beat), .rd_data(m_wdata)
  );

  assign m_addr = m_we ? cur_dst : cur_src;
  assign m_size = cfg_size;
  assign irq    = done & cfg_irq_en;

  // the interrupt only rises while enabled and with the flag set
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> cfg_irq_en && done);
endmodule

// File: tb/test_mdma_channel.sv
`timescale 1ns/1ps
module test_mdma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_src_start = '0, cfg_dst_start = '0;
  logic [7:0]  cfg_src_inc = '0, cfg_dst_inc = '0;
  logic [23:0] cfg_src_mask = '0, cfg_dst_mask = '0;
  logic [15:0] cfg_hops = '0;
  logic [1:0]  cfg_burst = '0, cfg_size = '0;
  logic [12:0] cfg_req_sel = '0, dreq = '0;
  logic        cfg_free_run = 1'b0, cfg_cont = 1'b0, cfg_lock = 1'b0, cfg_irq_en = 1'b0;
  logic        start = 1'b0, done_clr = 1'b0;
  logic        m_req, m_we, m_gnt = 1'b1;
  logic [31:0] m_addr, m_wdata, m_rdata, cur_src, cur_dst;
  logic [1:0]  m_size;
  logic        busy, done, irq;

  mdma_channel i_mdma_channel (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_start(cfg_src_start), .cfg_dst_start(cfg_dst_start),
    .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_src_mask(cfg_src_mask), .cfg_dst_mask(cfg_dst_mask),
    .cfg_hops(cfg_hops), .cfg_burst(cfg_burst), .cfg_size(cfg_size),
    .cfg_req_sel(cfg_req_sel), .cfg_free_run(cfg_free_run), .cfg_cont(cfg_cont),
    .cfg_lock(cfg_lock), .cfg_irq_en(cfg_irq_en), .start(start), .done_clr(done_clr),
    .dreq(dreq), .m_req(m_req), .m_gnt(m_gnt), .m_we(m_we), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata), .cur_src(cur_src),
    .cur_dst(cur_dst), .busy(busy), .done(done), .irq(irq)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, grants = 0;
  bit stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_rd[$];
  logic [63:0] exp_wr[$];
  int exp_gap = 0, last_rd_cyc = 0;
  bit prev_rd = 1'b0;
  logic [31:0] ms = '0, md = '0;

  // source memory model: data is a pure function of the address
  assign m_rdata = {~m_addr[15:0], m_addr[15:0]};

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_next(input logic [31:0] now, input logic [31:0] base,
                                           input logic [7:0] inc, input logic [23:0] msk);
    logic [31:0] s;
    s = now + {{24{inc[7]}}, inc};
    for (int i = 4; i < 28; i++)
      if (msk[i-4]) s[i] = base[i];
    return s;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_gnt <= stall ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor: compare every granted beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n && m_req && m_gnt) begin
      grants++;
      chk(m_size == cfg_size, "R10 size", m_size, cfg_size);
      if (!m_we) begin
        if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected read", m_addr, 0);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(m_addr == e, "R3 R4 read address", m_addr, e);
        end
        prev_rd = 1'b1;
        last_rd_cyc = cyc;
      end else begin
        if (prev_rd && exp_gap != 0)
          chk(cyc - last_rd_cyc == exp_gap, "R7 read-to-write spacing", cyc - last_rd_cyc, exp_gap);
        prev_rd = 1'b0;
        if (exp_wr.size() == 0) chk(1'b0, "R2 unexpected write", m_addr, 0);
        else begin
          logic [63:0] e;
          e = exp_wr.pop_front();
          chk({m_addr, m_wdata} == e, "R2 R3 R4 write addr/data", {m_addr, m_wdata}, e);
        end
      end
    end
  end

  task automatic plan_hop(input int nb);
    logic [31:0] d [4];
    for (int b = 0; b < nb; b++) begin
      exp_rd.push_back(ms);
      d[b] = {~ms[15:0], ms[15:0]};
      ms = ref_next(ms, cfg_src_start, cfg_src_inc, cfg_src_mask);
    end
    for (int b = 0; b < nb; b++) begin
      exp_wr.push_back({md, d[b]});
      md = ref_next(md, cfg_dst_start, cfg_dst_inc, cfg_dst_mask);
    end
  endtask

  task automatic wait_grants(input int target);
    for (int t = 0; t < 2000 && grants < target; t++) @(negedge clk);
  endtask

  task automatic run_job(input bit free, input bit lock, input logic [1:0] bsel,
                         input int hops, input bit cont, input bit ien, input bit stl,
                         input int rbit);
    int nb;
    cfg_free_run = free; cfg_lock = lock; cfg_burst = bsel; cfg_hops = 16'(hops);
    cfg_cont = cont; cfg_irq_en = ien; cfg_req_sel = 13'(1) << 5;
    stall = stl;
    @(negedge clk);
    if (!cont) begin ms = cfg_src_start; md = cfg_dst_start; end
    nb = (bsel == 2'd0) ? 1 : (bsel == 2'd1) ? 2 : 4;
    for (int h = 0; h < hops; h++) plan_hop(nb);
    exp_gap = stl ? 0 : (lock ? 1 : 2);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (!free) begin
      int g0;
      logic [31:0] s0;
      // R5: an unselected line must start nothing
      g0 = grants; s0 = cur_src;
      dreq[2] = 1'b1; @(negedge clk); dreq[2] = 1'b0;
      repeat (20) @(negedge clk);
      chk(grants == g0 && cur_src == s0 && busy, "R5 unselected request ignored", grants, g0);
      for (int h = 0; h < hops; h++) begin
        g0 = grants;
        dreq[rbit] = 1'b1; @(negedge clk); dreq[rbit] = 1'b0;
        wait_grants(g0 + 2 * nb);
        repeat (6) @(negedge clk);
        chk(grants == g0 + 2 * nb, "R5 one hop per request", grants, g0 + 2 * nb);
      end
    end
    for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
    @(negedge clk);
    chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R2 R6 all beats seen",
        exp_rd.size() + exp_wr.size(), 0);
    chk(!busy && done, "R8 done after last hop", {busy, done}, 2'b01);
    chk(irq == ien, "R8 irq follows enable", irq, ien);
    chk(cur_src == ms, "R3 final source address", cur_src, ms);
    chk(cur_dst == md, "R3 final destination address", cur_dst, md);
    stall = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!m_req && !busy && !done && !irq, "R1 reset outputs", {m_req, busy, done, irq}, 0);
    chk(cur_src == 0 && cur_dst == 0, "R1 reset addresses", {cur_src, cur_dst}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // free-running, locked, 4 beats
    cfg_size = 2'd2;
    cfg_src_start = 32'h0000_1000; cfg_src_inc = 8'h04; cfg_src_mask = '0;
    cfg_dst_start = 32'h0000_2000; cfg_dst_inc = 8'h04; cfg_dst_mask = '0;
    run_job(1, 1, 2'd2, 3, 0, 1, 0, 5);
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0; @(negedge clk);
    chk(!done && !irq, "R8 done_clr clears flag", {done, irq}, 0);

    // R4 circular source window, fixed-window destination with negative step, no lock
    cfg_src_start = 32'h0000_3010; cfg_src_inc = 8'h08; cfg_src_mask = 24'hFFFFFE;
    cfg_dst_start = 32'h0000_4000; cfg_dst_inc = 8'hFC; cfg_dst_mask = 24'hFFFFFF;
    cfg_size = 2'd0;
    run_job(1, 0, 2'd1, 4, 0, 0, 0, 5);

    // R5 request-driven, single beat hops
    cfg_src_start = 32'h0000_5000; cfg_src_inc = 8'h04; cfg_src_mask = '0;
    cfg_dst_start = 32'h0000_6000; cfg_dst_inc = 8'h04; cfg_dst_mask = '0;
    run_job(0, 1, 2'd0, 3, 0, 1, 0, 5);

    // R4 mask bit 23 freezes address bit 27 across a carry; selector 3 gives 4 beats; stalls
    cfg_src_start = 32'h07FF_FFF0; cfg_src_inc = 8'h08; cfg_src_mask = 24'h800000;
    cfg_dst_start = 32'h0000_7000; cfg_dst_inc = 8'h04; cfg_dst_mask = '0;
    cfg_size = 2'd1;
    run_job(1, 0, 2'd3, 2, 0, 1, 1, 5);

    // R9 continue from where the last run stopped
    run_job(1, 1, 2'd1, 2, 1, 1, 1, 5);

    // R8 zero-hop start
    begin
      int g0;
      g0 = grants;
      cfg_hops = '0; cfg_cont = 1'b0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (5) @(negedge clk);
      chk(done && !busy && grants == g0, "R8 zero hops completes at once", {done, busy}, 2'b10);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule